// File: doc/BRIEF.md
# Read/Write Master Request Arbiter

This block chooses which of two FIFO-driven bus-master requests is allowed to own the bus. The read request asks to fetch data into the inbound FIFO and the write request asks to drain the outbound FIFO. Two priority-control bits choose between a fixed preference for reads, a fixed preference for writes, or turn-taking between the two. The block produces one registered grant line per direction, and no more than one of them is ever high.

A decision is made only on a clock edge where neither direction holds a grant and the shared bus is not busy. Once a grant is issued, it stays up until the end-of-transfer indication is seen. After that, both grants are low for one cycle, and the next decision can be made at the following edge. A transfer in progress is never handed to the other direction. The logic that raises the requests and the bus protocol sequencing are outside this block.

All inputs are sampled on the rising edge of `clk`. A decision made at edge k shows on the grant outputs right after edge k.

Top module: `rw_master_arbiter`

## Requirements
- R1: While `rst_n` is low, and right after it is released, both grants are low. Reset also sets the turn-taking preference to read. This holds even when reset is applied in the middle of a transfer.
- R2: `rd_grant` and `wr_grant` are never high at the same time.
- R3: A grant rises only at an edge where both grants were low, `bus_busy` was low and at least one request was high. If `bus_busy` is high or no request is pending, both grants stay low.
- R4: When exactly one request is pending at a decision, that direction is granted, whatever the priority bits are.
- R5: With `rd_pri`=1 and `wr_pri`=0, a decision with both requests pending grants read.
- R6: With `rd_pri`=0 and `wr_pri`=1, a decision with both requests pending grants write.
- R7: With `rd_pri` equal to `wr_pri` (both 0 or both 1), a decision with both requests pending grants the preferred direction. The first such grant after reset is a read. After every issued grant, in any mode, the preference becomes the direction not granted. Cycles without a grant never change the preference.
- R8: A held grant stays high, and does not move to the other direction, until `xfer_done` is sampled high. Changes on the requests, the priority bits and `bus_busy` do not affect it.
- R9: When `xfer_done` is sampled high while a grant is held, both grants are low after that edge for exactly one cycle. A pending request is granted at the following edge.
- R10: `xfer_done` has no effect while no grant is held. A pending request is still granted at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read bus-master request (fill inbound FIFO) |
| wr_req | input | 1 | Write bus-master request (drain outbound FIFO) |
| rd_pri | input | 1 | Read-priority control bit |
| wr_pri | input | 1 | Write-priority control bit |
| bus_busy | input | 1 | Bus is occupied; no decision may be made |
| xfer_done | input | 1 | End of the current granted transfer |
| rd_grant | output | 1 | Registered grant for the read direction |
| wr_grant | output | 1 | Registered grant for the write direction |

## Verification
The bench sweeps every pairing of the two priority bits against every combination of the two requests, each with the bus idle and with the bus busy. This separates the single-request rule, the two fixed-priority modes and turn-taking, and shows that a busy bus blocks every decision. Long runs with both requests held high, in both encodings of turn-taking mode, show that the first grant after reset is a read and that the directions strictly alternate. Separate sequences check three things: a held grant ignores every other input, the gap after end-of-transfer is exactly one cycle, and `xfer_done` is ignored while no grant is held.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    PRI_ALT = 2'd0,
    PRI_RD  = 2'd1,
    PRI_WR  = 2'd2
  } pri_mode_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_RD   = 2'd1,
    DIR_WR   = 2'd2
  } dir_e;

  // Equal priority bits mean turn-taking.
  function automatic pri_mode_e decode_mode(input logic rp, input logic wp);
    if (rp == wp) return PRI_ALT;
    return rp ? PRI_RD : PRI_WR;
  endfunction

  function automatic dir_e pick_dir(input logic rq, input logic wq,
                                    input pri_mode_e m, input logic turn_wr);
    if (!rq && !wq) return DIR_NONE;
    if (rq && !wq)  return DIR_RD;
    if (wq && !rq)  return DIR_WR;
    case (m)
      PRI_RD:  return DIR_RD;
      PRI_WR:  return DIR_WR;
      default: return turn_wr ? DIR_WR : DIR_RD;
    endcase
  endfunction

endpackage

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
(
  input  logic rd_req,
  input  logic wr_req,
  input  logic rd_pri,
  input  logic wr_pri,
  input  logic turn_wr,
  output dir_e want
);
  pri_mode_e mode;

  always_comb begin
    mode = decode_mode(rd_pri, wr_pri);
    want = pick_dir(rd_req, wr_req, mode, turn_wr);
  end
endmodule

// File: rtl/arb_turn_reg.sv
module arb_turn_reg
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue_ev,
  input  dir_e issued,
  output logic turn_wr
);
  // Preference flips to the direction that was not just granted.
  always_ff @(posedge clk) begin
    if (!rst_n)        turn_wr <= 1'b0;
    else if (issue_ev) turn_wr <= (issued == DIR_RD);
  end
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_busy,
  input  logic xfer_done,
  input  dir_e want,
  output logic issue_ev,
  output logic release_ev,
  output logic rd_grant,
  output logic wr_grant
);
  logic idle;

  always_comb begin
    idle       = !rd_grant && !wr_grant;
    issue_ev   = idle && !bus_busy && (want != DIR_NONE);
    release_ev = !idle && xfer_done;
  end

  // The grant flops are the only state: both low means idle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_grant <= 1'b0;
      wr_grant <= 1'b0;
    end else if (issue_ev) begin
      rd_grant <= (want == DIR_RD);
      wr_grant <= (want == DIR_WR);
    end else if (release_ev) begin
      rd_grant <= 1'b0;
      wr_grant <= 1'b0;
    end
  end
endmodule

// File: rtl/rw_master_arbiter.sv
module rw_master_arbiter
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic wr_req,
  input  logic rd_pri,
  input  logic wr_pri,
  input  logic bus_busy,
  input  logic xfer_done,
  output logic rd_grant,
  output logic wr_grant
);
  dir_e want;
  logic turn_wr;
  logic issue_ev;
  logic release_ev;

  arb_pick u_pick (
    .rd_req  (rd_req),
    .wr_req  (wr_req),
    .rd_pri  (rd_pri),
    .wr_pri  (wr_pri),
    .turn_wr (turn_wr),
    .want    (want)
  );

  arb_turn_reg u_turn (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_ev (issue_ev),
    .issued   (want),
    .turn_wr  (turn_wr)
  );

  arb_grant_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_busy   (bus_busy),
    .xfer_done  (xfer_done),
    .want       (want),
    .issue_ev   (issue_ev),
    .release_ev (release_ev),
    .rd_grant   (rd_grant),
    .wr_grant   (wr_grant)
  );
endmodule

// File: rtl/rw_master_arbiter_chk.sv
module rw_master_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic wr_req,
  input logic rd_pri,
  input logic wr_pri,
  input logic bus_busy,
  input logic xfer_done,
  input logic rd_grant,
  input logic wr_grant,
  input logic issue_ev,
  input logic release_ev
);
  logic idle;
  assign idle = !rd_grant && !wr_grant;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_grant && wr_grant));

  assert_busy_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && bus_busy) |=> idle);

  assert_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !rd_req && !wr_req) |=> idle);

  assert_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ev |=> !idle);

  assert_single_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !bus_busy && rd_req && !wr_req) |=> rd_grant);

  assert_single_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !bus_busy && wr_req && !rd_req) |=> wr_grant);

  assert_rd_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !bus_busy && rd_req && wr_req && rd_pri && !wr_pri) |=> rd_grant);

  assert_wr_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !bus_busy && rd_req && wr_req && !rd_pri && wr_pri) |=> wr_grant);

  assert_hold_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant && !xfer_done) |=> rd_grant);

  assert_hold_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant && !xfer_done) |=> wr_grant);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> idle);

  assert_release_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && xfer_done) |-> release_ev);
endmodule

bind rw_master_arbiter rw_master_arbiter_chk chk_i (.*);

// File: tb/rw_master_arbiter_tb.sv
module rw_master_arbiter_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, rd_req, wr_req, rd_pri, wr_pri, bus_busy, xfer_done;
  logic rd_grant, wr_grant;
  int   n_tests = 0;
  int   n_fail  = 0;
  logic turn_wr_m;

  rw_master_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .rd_pri(rd_pri), .wr_pri(wr_pri), .bus_busy(bus_busy),
    .xfer_done(xfer_done), .rd_grant(rd_grant), .wr_grant(wr_grant)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [1:0] exp);
    logic [1:0] act;
    act = {wr_grant, rd_grant};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: grants {wr,rd} got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic rq, input logic wq,
                                       input logic rp, input logic wp,
                                       input logic busy);
    if (busy || (!rq && !wq)) return 2'b00;
    if (rq && !wq) return 2'b01;
    if (wq && !rq) return 2'b10;
    if (rp != wp)  return rp ? 2'b01 : 2'b10;
    return turn_wr_m ? 2'b10 : 2'b01;
  endfunction

  function automatic string tag_of(input logic rq, input logic wq,
                                   input logic rp, input logic wp,
                                   input logic busy);
    if (busy || (!rq && !wq)) return "R3";
    if (rq != wq) return "R4";
    if (rp && !wp) return "R5";
    if (wp && !rp) return "R6";
    return "R7";
  endfunction

  function automatic void note_grant(input logic [1:0] g);
    if (g == 2'b01) turn_wr_m = 1'b1;
    if (g == 2'b10) turn_wr_m = 1'b0;
  endfunction

  task automatic finish_xfer(input string tag);
    rd_req = 0; wr_req = 0; xfer_done = 1;
    tick();
    chk(tag, 2'b00);
    xfer_done = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; rd_req = 0; wr_req = 0; rd_pri = 0; wr_pri = 0;
    bus_busy = 0; xfer_done = 0;
    tick(); tick();
    turn_wr_m = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] e;
    do_reset();
    chk("R1 in reset", 2'b00);
    rst_n = 1;
    tick();
    chk("R1 after release", 2'b00);

    // R7: both priority encodings of turn-taking, both requests held
    for (int enc = 0; enc < 2; enc++) begin
      rd_pri = enc[0]; wr_pri = enc[0];
      rd_req = 1; wr_req = 1;
      tick();
      for (int i = 0; i < 6; i++) begin
        e = turn_wr_m ? 2'b10 : 2'b01;
        if (enc == 0 && i == 0) chk("R7 first grant after reset is read", 2'b01);
        chk("R7 alternation", e);
        note_grant(e);
        xfer_done = 1;
        tick();
        chk("R9 one-cycle gap", 2'b00);
        xfer_done = 0;
        tick();
      end
      e = turn_wr_m ? 2'b10 : 2'b01;
      chk("R9 regrant after gap", e);
      note_grant(e);
      finish_xfer("R9 release");
    end

    // R7: idle cycles do not move the preference
    rd_pri = 0; wr_pri = 0;
    repeat (3) tick();
    rd_req = 1; wr_req = 1;
    tick();
    e = turn_wr_m ? 2'b10 : 2'b01;
    chk("R7 idle cycles keep preference", e);
    note_grant(e);
    finish_xfer("R9 release");

    // Sweep of mode x requests x busy
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        for (int b = 0; b < 2; b++) begin
          rd_pri = m[0]; wr_pri = m[1];
          rd_req = r[0]; wr_req = r[1]; bus_busy = b[0];
          e = model(r[0], r[1], m[0], m[1], b[0]);
          tick();
          chk(tag_of(r[0], r[1], m[0], m[1], b[0]), e);
          bus_busy = 0;
          if (e != 2'b00) begin
            note_grant(e);
            finish_xfer("R9 release in sweep");
          end else begin
            rd_req = 0; wr_req = 0;
          end
        end
      end
    end

    // R3: busy held for several cycles, then freed
    rd_pri = 1; wr_pri = 0; rd_req = 1; wr_req = 1; bus_busy = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 busy blocks decision", 2'b00);
    end
    bus_busy = 0;
    tick();
    chk("R3 decision once bus free", 2'b01);
    note_grant(2'b01);

    // R8: held grant ignores every other input
    for (int i = 0; i < 5; i++) begin
      rd_req = i[0]; wr_req = 1; rd_pri = 0; wr_pri = 1; bus_busy = i[1];
      tick();
      chk("R8 grant held", 2'b01);
    end
    bus_busy = 0;
    finish_xfer("R9 release after hold");

    // R10: end-of-transfer ignored while idle
    rd_pri = 0; wr_pri = 1; rd_req = 0; wr_req = 1; xfer_done = 1;
    tick();
    chk("R10 done ignored while idle", 2'b10);
    note_grant(2'b10);
    xfer_done = 0;
    tick();
    chk("R8 grant held after idle done", 2'b10);

    // R1: reset in mid-transfer clears grant and preference
    rst_n = 0;
    tick();
    chk("R1 reset mid-transfer", 2'b00);
    turn_wr_m = 1'b0;
    rst_n = 1; rd_pri = 1; wr_pri = 1; rd_req = 1; wr_req = 1;
    tick();
    chk("R7 first grant after second reset is read", 2'b01);
    note_grant(2'b01);
    finish_xfer("R9 release");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule